// File: doc/BRIEF.md
# Dual-Source Clock Output Divider

This block produces a set of divided clock outputs, one per channel. Each channel takes one of two reference clocks, either the slow 32768 Hz timekeeping clock or a fast clock of about 4 MHz. It divides that clock by a ratio set in an 8-bit control byte, and gates the result with an enable bit. The control bytes sit at consecutive addresses of a small write/read port, one byte per channel. Every channel runs on its own.

The block runs on one system clock that must be much faster than either reference. Each reference passes through a synchronizer and an edge detector that all channels share. A channel counts rising edges of the reference it has selected and toggles its output after half the division ratio. When the ratio is one, the output follows the synchronized reference level instead. The fast reference first goes through a pre-divider. Its ratios are powers of two from 1 to 64, plus one setting of 122. A power-of-two post-divider follows. The slow reference skips the pre-divider and goes straight to the post-divider.

Top module: `clkdiv_out_top`

## Requirements
- R1: After reset every control byte reads 0x00 and every output is low.
- R2: A write with `wr_addr` below the channel count updates that channel's control byte at the next clock edge. A write to a higher address changes nothing. `rd_data` returns the byte at `rd_addr` one cycle later, or 0x00 for an unused address.
- R3: While bit 0 of a channel's control byte is 0, the output of that channel is low from the next cycle on.
- R4: Bit 4 selects the reference: 0 is the 32768 Hz clock (`rtc_clk_i`) and 1 is the fast clock (`aud_clk_i`).
- R5: Bits 3:1 form a post-divider code c, which divides by 2^c.
- R6: Bits 7:5 form a pre-divider code. Codes 0 to 6 divide by 2^code and code 7 divides by 122. This stage applies only to the fast reference.
- R7: With the slow reference selected, the pre-divider code has no effect on the output.
- R8: When the total ratio is 1, the output copies the synchronized reference: it has the same period and the same high time.
- R9: When the total ratio N is 2 or more, the output period is N reference periods and the high time is exactly N/2 reference periods. This includes the ratios built from 122.
- R10: A new control byte written while a channel runs takes effect only at that channel's next output transition, so the phase in progress finishes at its old length.
- R11: Each channel keeps its own ratio whatever the other channels are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either reference |
| rst | input | 1 | Synchronous active-high reset |
| rtc_clk_i | input | 1 | 32768 Hz reference, asynchronous |
| aud_clk_i | input | 1 | Fast (~4 MHz) reference, asynchronous |
| wr_en | input | 1 | Control byte write strobe |
| wr_addr | input | AW | Channel index of the write |
| wr_data | input | 8 | Control byte to write |
| rd_addr | input | AW | Channel index of the read |
| rd_data | output | 8 | Registered control byte read back |
| clk_out | output | NCH | Divided, gated clock output per channel |

## Verification
The checker covers the register side and the gate on every cycle. It checks the reset values, that each write lands on the addressed channel and leaves the other channels alone, and that the output stays low whenever the enable bit is clear. The division ratios depend on counting over hundreds of cycles, so only the bench's scenarios can show them. Those scenarios measure output period and high time for the bypass, power-of-two and 122-based ratios on both references. They also show that the pre-divider is ignored on the slow path, that channels stay independent, and that a code change mid-phase leaves the current phase at its old length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CTRL_W  = 8;
  localparam int POST_W  = 3;
  localparam int PRE_W   = 3;
  localparam int PRE_TOP = 122;
  localparam int RATIO_W = $clog2(PRE_TOP << ((1 << POST_W) - 1)) + 1;

  // field layout of one control byte, MSB first
  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic              src;
    logic [POST_W-1:0] post;
    logic              en;
  } ctrl_t;

  function automatic logic [7:0] pre_ratio(input logic [PRE_W-1:0] code);
    if (code == {PRE_W{1'b1}}) pre_ratio = 8'(PRE_TOP);
    else                       pre_ratio = 8'd1 << code;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input ctrl_t c);
    logic [RATIO_W-1:0] base;
    base = c.src ? RATIO_W'(pre_ratio(c.pre)) : RATIO_W'(1);
    ratio_of = base << c.post;
  endfunction
endpackage

// File: rtl/clkdiv_edge_sync.sv
module clkdiv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign edge_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CTRL_W-1:0] rd_data,
  output ctrl_t             ctrl_q [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                        ctrl_q[g] <= '0;
      else if (wr_en && (32'(wr_addr) == g))          ctrl_q[g] <= ctrl_t'(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         rd_data <= '0;
    else if (32'(rd_addr) < NCH)     rd_data <= ctrl_q[rd_addr];
    else                             rd_data <= '0;
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_t      ctrl,
  input  logic [1:0] lvl_i,
  input  logic [1:0] rise_i,
  output logic       clk_o
);
  ctrl_t              act;
  logic [RATIO_W-1:0] ratio, half_m1, cnt;
  logic               bypass, nxt_bypass, lvl_sel, rise_sel;

  always_comb begin
    ratio      = ratio_of(act);
    half_m1    = (ratio >> 1) - RATIO_W'(1);
    bypass     = (ratio == RATIO_W'(1));
    nxt_bypass = (ratio_of(ctrl) == RATIO_W'(1));
    lvl_sel    = lvl_i[act.src];
    rise_sel   = rise_i[act.src];
  end

  // the active setting is reloaded only at an output transition
  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= '0;
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (!ctrl.en) begin
      act   <= ctrl;
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (bypass) begin
      clk_o <= lvl_sel;
      if (rise_sel) begin
        act <= ctrl;
        cnt <= '0;
      end
    end else if (rise_sel) begin
      if (cnt == half_m1) begin
        cnt   <= '0;
        act   <= ctrl;
        clk_o <= nxt_bypass ? 1'b1 : ~clk_o;
      end else begin
        cnt <= cnt + RATIO_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_out_top.sv
module clkdiv_out_top
  import clkdiv_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_clk_i,
  input  logic              aud_clk_i,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CTRL_W-1:0] rd_data,
  output logic [NCH-1:0]    clk_out
);
  ctrl_t                 ctrl_q [NCH];
  logic [NCH*CTRL_W-1:0] ctrl_flat;
  logic [1:0]            src_raw, src_lvl, src_rise, src_edge;

  assign src_raw = {aud_clk_i, rtc_clk_i};

  for (genvar s = 0; s < 2; s++) begin : g_sync
    clkdiv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(src_raw[s]),
      .lvl_o(src_lvl[s]), .rise_o(src_rise[s]), .edge_o(src_edge[s])
    );
  end

  clkdiv_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_q(ctrl_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctrl_flat[g*CTRL_W +: CTRL_W] = ctrl_q[g];
    clkdiv_chan u_ch (
      .clk(clk), .rst(rst), .ctrl(ctrl_q[g]),
      .lvl_i(src_lvl), .rise_i(src_rise), .clk_o(clk_out[g])
    );
  end
endmodule

// File: rtl/clkdiv_out_chk.sv
module clkdiv_out_chk #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [7:0]        wr_data,
  input logic [NCH*8-1:0]  ctrl_flat,
  input logic [NCH-1:0]    clk_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ctrl_flat[g*8 +: 8] == 8'h00 && !clk_out[g]));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && 32'(wr_addr) == g) |=> (ctrl_flat[g*8 +: 8] == $past(wr_data)));
    // R2
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && 32'(wr_addr) == g) |=> $stable(ctrl_flat[g*8 +: 8]));
    // R3
    gate_low_chk: assert property (@(posedge clk) disable iff (rst)
      !ctrl_flat[g*8] |=> !clk_out[g]);
  end
endmodule

bind clkdiv_out_top clkdiv_out_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_flat(ctrl_flat), .clk_out(clk_out)
);

// File: tb/sim_clkdiv_out_top.sv
`timescale 1ns/1ps
module sim_clkdiv_out_top;
  localparam int NCH = 3;
  localparam int AW  = 2;
  localparam int RTC_P = 10;  // reference periods in system cycles
  localparam int AUD_P = 4;

  logic clk = 0, rst = 1, rtc = 0, aud = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [NCH-1:0] clk_out;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct { int ch; int per; int high; string tag; } exp_t;
  exp_t exp_q[$];

  clkdiv_out_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .rtc_clk_i(rtc), .aud_clk_i(aud),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
  );

  always #5 clk = ~clk;
  always #50 rtc = ~rtc;
  always #20 aud = ~aud;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  // driver: program, let old setting drain, queue the expected waveform
  task automatic run_case(input int ch, input logic [7:0] c, input int per,
                          input int high, input string tag);
    exp_t e;
    wr(ch, c);
    repeat (1500) @(negedge clk);
    e.ch = ch; e.per = per; e.high = high; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  // monitor: measure one full period and its high time
  logic prv = 1, cur, seen_r = 0, seen_f = 0;
  int tr = 0, tf = 0;
  always @(negedge clk) begin
    if (exp_q.size() == 0) begin
      seen_r = 0; prv = 1;
    end else begin
      cur = clk_out[exp_q[0].ch];
      if (cur && !prv) begin
        if (seen_r && seen_f) begin
          chk(cyc - tr == exp_q[0].per, {exp_q[0].tag, " period"}, cyc - tr, exp_q[0].per);
          chk(tf - tr == exp_q[0].high, {exp_q[0].tag, " high"}, tf - tr, exp_q[0].high);
          void'(exp_q.pop_front());
          seen_r = 0;
        end else begin
          seen_r = 1; seen_f = 0; tr = cyc;
        end
      end else if (!cur && prv && seen_r) begin
        tf = cyc; seen_f = 1;
      end
      prv = cur;
    end
  end

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int highs, t0, th, tl;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(clk_out == '0, "R1 outputs low", int'(clk_out), 0);
    for (int i = 0; i < NCH; i++) begin
      rd(i, d);
      chk(d == 8'h00, "R1 reset byte", d, 0);
    end

    // R2: readback, and an unused address ignored
    wr(0, 8'h5A); wr(1, 8'hC4); wr(2, 8'h38); wr(3, 8'hFF);
    rd(0, d); chk(d == 8'h5A, "R2 ch0 readback", d, 8'h5A);
    rd(1, d); chk(d == 8'hC4, "R2 ch1 readback", d, 8'hC4);
    rd(2, d); chk(d == 8'h38, "R2 ch2 after stray write", d, 8'h38);
    rd(3, d); chk(d == 8'h00, "R2 unused address", d, 0);
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);

    // R8/R4: ratio 1 on each reference
    run_case(0, 8'h01, RTC_P, RTC_P/2, "R8 R4 slow bypass");
    run_case(0, 8'h11, AUD_P, AUD_P/2, "R8 R4 fast bypass");
    // R5/R7: slow reference post /8, pre code 7 must be ignored
    run_case(0, 8'hE7, 8*RTC_P, 4*RTC_P, "R5 R7 slow post8 pre ignored");
    // R6/R5: fast reference pre /8 post /4
    run_case(0, 8'h75, 32*AUD_P, 16*AUD_P, "R6 R5 fast 8x4");
    // R6/R9: the 122 setting
    run_case(1, 8'hF1, 122*AUD_P, 61*AUD_P, "R6 R9 fast 122");
    run_case(2, 8'hF3, 244*AUD_P, 122*AUD_P, "R9 fast 122x2");
    run_case(2, 8'h0F, 128*RTC_P, 64*RTC_P, "R5 R9 slow post128");
    // R11: change ch2, ch1 keeps its ratio
    run_case(2, 8'h05, 4*RTC_P, 2*RTC_P, "R11 ch2 new ratio");
    begin
      exp_t e;
      e.ch = 1; e.per = 122*AUD_P; e.high = 61*AUD_P; e.tag = "R11 ch1 unchanged";
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
    end

    // R3: disable holds ch0 low while references run
    wr(0, 8'h00);
    highs = 0;
    repeat (300) begin
      @(negedge clk);
      if (clk_out[0]) highs++;
    end
    chk(highs == 0, "R3 disabled output high cycles", highs, 0);

    // R10: code change mid-phase leaves the phase in progress at old length
    wr(1, 8'h33);
    repeat (1500) @(negedge clk);
    while (clk_out[1]) @(negedge clk);
    while (!clk_out[1]) @(negedge clk);
    t0 = cyc;
    wr_en = 1; wr_addr = 2'd1; wr_data = 8'hF1;
    @(negedge clk);
    wr_en = 0;
    while (clk_out[1]) @(negedge clk);
    th = cyc;
    while (!clk_out[1]) @(negedge clk);
    tl = cyc;
    chk(th - t0 == 2*AUD_P, "R10 old high phase kept", th - t0, 2*AUD_P);
    chk(tl - th == 61*AUD_P, "R10 new low phase", tl - th, 61*AUD_P);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule